// File: doc/BRIEF.md
# Scanned multi-register serial transmitter

The block holds one frame of pixel data as a set of short shift registers, `GROUPS` of them, each `WIDTH` bits wide. A scanner selects one register at a time and shifts it out onto a single serial line. After the last bit of that register it moves on to the next register, until every register has been sent. Only the selected register receives a shift enable, so the other registers stay static. The registers rotate rather than empty, so after a frame each register holds its original word again. The same frame can therefore be sent again without reloading it.

Words are loaded over a valid/ready stream. Each accepted beat fills the next register in ascending order, and the write position wraps back to register 0 after the last one. `load_ready` is high only while no frame is in flight, so a load offered during a frame simply waits. The serial output is also a valid/ready stream. `ser_valid` acts as the frame-active flag. A bit moves on only in a cycle where both `ser_valid` and `ser_ready` are high, and a low `ser_ready` freezes the line and the scan position. `start` and `frame_done` are plain control pins. The defaults are 8 groups of 14 bits. The block is also meant to be built with 14-bit groups and 32, 128 or 256 groups.

Top module: `scan_serial_tx`

## Requirements
- R1: After reset, `ser_valid` is 0, `ser_bit` is 0, `frame_done` is 0, `load_ready` is 1, and all registers hold zero.
- R2: Accepted load beats (`load_valid` and `load_ready` both high) write registers 0, 1, ... `GROUPS-1` in order. The next beat after that wraps back to register 0. Only reset clears the write position.
- R3: While a frame is in flight `load_ready` is 0 and `load_valid` has no effect on any register.
- R4: When `start` is high in an idle cycle, `ser_valid` is 1 from the next cycle on, with the MSB of register 0 on `ser_bit`. When `start` is high during a frame it is ignored.
- R5: A frame is exactly `GROUPS*WIDTH` transfers. Registers go in ascending index order, and each register sends its bits from bit `WIDTH-1` down to bit 0.
- R6: A transfer happens only in a cycle with `ser_valid` and `ser_ready` both high. While `ser_ready` is 0, `ser_bit` and the scan position hold.
- R7: In the cycle after the last transfer of a frame, `ser_valid` is 0 and `frame_done` is 1. `frame_done` is high for exactly that one cycle.
- R8: While `ser_valid` is 0, `ser_bit` is 0.
- R9: Only the selected register shifts, and it rotates. A second `start` without a reload sends the identical bit stream.
- R10: At no time does more than one register receive a shift enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Load word offered |
| load_ready | output | 1 | Load word can be accepted (block idle) |
| load_data | input | WIDTH | Word for the next register in sequence |
| start | input | 1 | Begin a frame (acted on only when idle) |
| ser_valid | output | 1 | Frame active; serial bit is valid |
| ser_ready | input | 1 | Receiver takes the current bit |
| ser_bit | output | 1 | Serial data, 0 when idle |
| frame_done | output | 1 | One-cycle pulse after the last bit of a frame |

## Verification
The assertions assume that `start` and `load_valid` are held stable around the clock edge, and that the receiver may drop `ser_ready` in any cycle. Nothing is assumed about how `start` and `load_valid` are timed relative to a frame. To keep to this, the bench drives every input just after the rising edge. It pulses `start` and offers loads in the middle of frames. It also toggles `ser_ready` at random, and it holds `ser_ready` low for a long run partway through a frame. The frame-length counter in the checker restarts on each frame, so it relies on a frame ending with `frame_done` before the next frame begins, which the block itself enforces.

// File: rtl/scan_tx_pkg.sv
package scan_tx_pkg;

  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_SEND = 1'b1
  } scan_state_e;

  function automatic int unsigned idx_bits(input int unsigned count);
    return (count < 2) ? 1 : $clog2(count);
  endfunction

endpackage

// File: rtl/scan_tx_group.sv
module scan_tx_group #(
  parameter int unsigned WIDTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift_en,
  output logic             top_bit
);

  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load_en) begin
      word_q <= load_word;
    end else if (shift_en) begin
      word_q <= {word_q[WIDTH-2:0], word_q[WIDTH-1]};
    end
  end

  assign top_bit = word_q[WIDTH-1];

endmodule

// File: rtl/scan_tx_loader.sv
module scan_tx_loader #(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned PW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              load_valid,
  output logic              load_ready,
  output logic [GROUPS-1:0] load_en
);

  logic [PW-1:0] wptr_q;
  logic          fire;
  logic          at_last;

  assign load_ready = !busy;
  assign fire       = load_valid && load_ready;
  assign at_last    = (wptr_q == PW'(GROUPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (fire) begin
      wptr_q <= at_last ? '0 : wptr_q + 1'b1;
    end
  end

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_dec
    assign load_en[gi] = fire && (wptr_q == PW'(gi));
  end

endmodule

// File: rtl/scan_tx_scanner.sv
module scan_tx_scanner
  import scan_tx_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned WIDTH  = 14,
  parameter int unsigned GW     = 3,
  parameter int unsigned BW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ser_ready,
  output logic              busy,
  output logic [GW-1:0]     grp,
  output logic [GROUPS-1:0] shift_en,
  output logic              done
);

  scan_state_e   state_q;
  logic [GW-1:0] grp_q;
  logic [BW-1:0] bcnt_q;
  logic          done_q;
  logic          xfer;
  logic          last_bit;
  logic          last_grp;

  assign busy     = (state_q == SCAN_SEND);
  assign xfer     = busy && ser_ready;
  assign last_bit = (bcnt_q == BW'(WIDTH - 1));
  assign last_grp = (grp_q == GW'(GROUPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      grp_q   <= '0;
      bcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SCAN_IDLE: begin
          if (start) begin
            state_q <= SCAN_SEND;
            grp_q   <= '0;
            bcnt_q  <= '0;
          end
        end
        SCAN_SEND: begin
          if (xfer) begin
            if (last_bit) begin
              bcnt_q <= '0;
              if (last_grp) begin
                grp_q   <= '0;
                state_q <= SCAN_IDLE;
                done_q  <= 1'b1;
              end else begin
                grp_q <= grp_q + 1'b1;
              end
            end else begin
              bcnt_q <= bcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_sel
    assign shift_en[gi] = xfer && (grp_q == GW'(gi));
  end

  assign grp  = grp_q;
  assign done = done_q;

endmodule

// File: rtl/scan_tx_outsel.sv
module scan_tx_outsel #(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned GW     = 3
) (
  input  logic [GROUPS-1:0] top_bits,
  input  logic [GW-1:0]     grp,
  input  logic              busy,
  output logic              ser_bit
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < GROUPS; i++) begin
      if (grp == GW'(i)) picked = top_bits[i];
    end
  end

  assign ser_bit = busy && picked;

endmodule

// File: rtl/scan_serial_tx.sv
module scan_serial_tx
  import scan_tx_pkg::*;
#(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned WIDTH  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [WIDTH-1:0] load_data,
  input  logic             start,
  output logic             ser_valid,
  input  logic             ser_ready,
  output logic             ser_bit,
  output logic             frame_done
);

  localparam int unsigned GW = idx_bits(GROUPS);
  localparam int unsigned BW = idx_bits(WIDTH);

  logic              busy;
  logic [GW-1:0]     grp;
  logic [GROUPS-1:0] shift_en;
  logic [GROUPS-1:0] load_en;
  logic [GROUPS-1:0] top_bits;

  scan_tx_loader #(.GROUPS(GROUPS), .PW(GW)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .load_valid (load_valid),
    .load_ready (load_ready),
    .load_en    (load_en)
  );

  scan_tx_scanner #(.GROUPS(GROUPS), .WIDTH(WIDTH), .GW(GW), .BW(BW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ser_ready (ser_ready),
    .busy      (busy),
    .grp       (grp),
    .shift_en  (shift_en),
    .done      (frame_done)
  );

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_reg
    scan_tx_group #(.WIDTH(WIDTH)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (load_en[gi]),
      .load_word (load_data),
      .shift_en  (shift_en[gi]),
      .top_bit   (top_bits[gi])
    );
  end

  scan_tx_outsel #(.GROUPS(GROUPS), .GW(GW)) u_out (
    .top_bits (top_bits),
    .grp      (grp),
    .busy     (busy),
    .ser_bit  (ser_bit)
  );

  assign ser_valid = busy;

endmodule

// File: rtl/scan_serial_tx_chk.sv
module scan_serial_tx_chk #(
  parameter int unsigned GROUPS = 8,
  parameter int unsigned WIDTH  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              load_ready,
  input logic              ser_valid,
  input logic              ser_ready,
  input logic              ser_bit,
  input logic              frame_done,
  input logic [GROUPS-1:0] shift_en
);

  localparam int unsigned TOTAL = GROUPS * WIDTH;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] xfer_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_done) begin
      xfer_cnt <= '0;
    end else if (ser_valid && ser_ready) begin
      xfer_cnt <= xfer_cnt + 1'b1;
    end
  end

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_bit);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_bit)));

  assert_no_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> !load_ready);

  assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ser_valid) |=> ser_valid);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!ser_valid && $past(ser_valid)));

  assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (xfer_cnt == CW'(TOTAL)));

  assert_one_shifter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(shift_en));

endmodule

bind scan_serial_tx scan_serial_tx_chk #(.GROUPS(GROUPS), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .load_ready (load_ready),
  .ser_valid  (ser_valid),
  .ser_ready  (ser_ready),
  .ser_bit    (ser_bit),
  .frame_done (frame_done),
  .shift_en   (shift_en)
);

// File: tb/scan_serial_tx_test.sv
`timescale 1ns/1ps
module scan_serial_tx_test;

  localparam int GROUPS = 8;
  localparam int WIDTH  = 14;
  localparam int TOTAL  = GROUPS * WIDTH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             load_valid = 1'b0;
  logic             load_ready;
  logic [WIDTH-1:0] load_data = '0;
  logic             start = 1'b0;
  logic             ser_valid;
  logic             ser_ready = 1'b0;
  logic             ser_bit;
  logic             frame_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int done_cnt = 0;
  bit rxq[$];

  logic [WIDTH-1:0] golden [GROUPS];
  int               g_wptr = 0;

  // behavioural reference state
  logic [WIDTH-1:0] m_mem [GROUPS];
  int  m_grp = 0, m_bit = 0, m_wptr = 0;
  bit  m_busy = 0, m_done = 0;

  always #2.5 clk = ~clk;

  scan_serial_tx #(.GROUPS(GROUPS), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .start(start), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .ser_bit(ser_bit), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GROUPS; i++) m_mem[i] = '0;
      m_grp = 0; m_bit = 0; m_wptr = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (ser_ready) begin
          m_mem[m_grp] = {m_mem[m_grp][WIDTH-2:0], m_mem[m_grp][WIDTH-1]};
          m_bit++;
          if (m_bit == WIDTH) begin
            m_bit = 0;
            m_grp++;
            if (m_grp == GROUPS) begin
              m_grp = 0; m_busy = 0; m_done = 1;
            end
          end
        end
      end else begin
        if (load_valid) begin
          m_mem[m_wptr] = load_data;
          m_wptr = (m_wptr + 1) % GROUPS;
        end
        if (start) begin
          m_busy = 1; m_grp = 0; m_bit = 0;
        end
      end
    end
  end

  // per-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ser_valid === m_busy, "R4 ser_valid vs model", int'(ser_valid), int'(m_busy));
      chk(ser_bit === (m_busy ? m_mem[m_grp][WIDTH-1] : 1'b0), "R5 ser_bit vs model",
          int'(ser_bit), int'(m_busy ? m_mem[m_grp][WIDTH-1] : 1'b0));
      chk(frame_done === m_done, "R7 frame_done vs model", int'(frame_done), int'(m_done));
      chk(load_ready === !m_busy, "R3 load_ready vs model", int'(load_ready), int'(!m_busy));
      if (!ser_valid) chk(ser_bit === 1'b0, "R8 idle line low", int'(ser_bit), 0);
      if (frame_done) done_cnt++;
      if (ser_valid && ser_ready) rxq.push_back(ser_bit);
    end
  end

  task automatic load_word(input logic [WIDTH-1:0] w);
    @(posedge clk); #1;
    load_valid = 1'b1; load_data = w;
    @(posedge clk); #1;
    load_valid = 1'b0;
    golden[g_wptr] = w;
    g_wptr = (g_wptr + 1) % GROUPS;
  endtask

  // mode 0: ready always; 1: random ready; 2: long stall; 3: random plus interference
  task automatic send_frame(input int mode, input string tag);
    int start_done;
    int guard;
    bit ok;
    rxq.delete();
    start_done = done_cnt;
    @(posedge clk); #1;
    start = 1'b1; ser_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    guard = 0;
    while (done_cnt == start_done && guard < 4000) begin
      guard++;
      case (mode)
        0: ser_ready = 1'b1;
        1: ser_ready = ($urandom_range(0, 2) != 0);
        2: ser_ready = !(guard >= 30 && guard < 45);
        default: begin
          ser_ready  = ($urandom_range(0, 1) != 0);
          load_valid = ($urandom_range(0, 3) == 0) && ser_valid;
          load_data  = WIDTH'($urandom);
          start      = ($urandom_range(0, 3) == 0) && ser_valid;
        end
      endcase
      if (mode == 2 && guard == 35) begin
        @(negedge clk);
        chk(ser_valid === 1'b1, {tag, " R6 valid held in stall"}, int'(ser_valid), 1);
      end
      @(posedge clk); #1;
      load_valid = 1'b0; start = 1'b0;
    end
    ser_ready = 1'b0;
    chk(done_cnt == start_done + 1, {tag, " R7 one done per frame"}, done_cnt - start_done, 1);
    chk(rxq.size() == TOTAL, {tag, " R5 frame length"}, rxq.size(), TOTAL);
    for (int g = 0; g < GROUPS; g++) begin
      ok = 1;
      for (int b = 0; b < WIDTH; b++) begin
        if (rxq.size() == TOTAL && rxq[g*WIDTH + b] !== golden[g][WIDTH-1-b]) ok = 0;
      end
      chk(ok, {tag, " R5 group content MSB first"}, g, g);
    end
  endtask

  initial begin
    for (int i = 0; i < GROUPS; i++) golden[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_valid === 1'b0, "R1 reset ser_valid", int'(ser_valid), 0);
    chk(ser_bit === 1'b0, "R1 reset ser_bit", int'(ser_bit), 0);
    chk(frame_done === 1'b0, "R1 reset frame_done", int'(frame_done), 0);
    chk(load_ready === 1'b1, "R1 reset load_ready", int'(load_ready), 1);

    send_frame(0, "R1 zero frame");

    for (int i = 0; i < GROUPS; i++) load_word(WIDTH'(16'h2A5B + i * 16'h0913));
    send_frame(0, "R5 plain");
    send_frame(1, "R9 resend random ready");
    send_frame(2, "R6 stall");
    send_frame(3, "R3 busy loads ignored");
    send_frame(0, "R9 after ignored loads");

    for (int i = 0; i < GROUPS + 2; i++) load_word(WIDTH'(16'h1FFF - i * 16'h0777));
    send_frame(1, "R2 wrap load");

    load_word({WIDTH{1'b1}});
    load_word('0);
    send_frame(0, "R2 continued pointer");

    repeat (5) begin
      @(negedge clk);
      chk(ser_bit === 1'b0, "R8 idle after frames", int'(ser_bit), 0);
    end
    finish_run();
  end

endmodule